// File: doc/BRIEF.md
# Dual-Bus Command Supersede Detector

This block sits beside the message engine of a remote terminal that listens on two redundant command/response buses. Word decoders ahead of it deliver one-cycle strobes: one when a valid command word completes and one when a data word completes, separately for each bus. The message engine reports whether it is receiving an incomplete message or transmitting a response, and on which bus. From these inputs the detector decides, once per clock, whether the message in flight must be dropped in favour of a newer command.

Two situations cause a supersede. In the first, a received message is left incomplete, its bus stays quiet for at least 3.5 us, and then a valid command arrives on either bus. In the second, the terminal is transmitting on one bus and a valid command starts on the other bus; this case has no gap requirement. A supersede produces an abort pulse, a start pulse for the new message with its bus, and a quash pulse. The quash pulse tells downstream bookkeeping to skip the dropped message: no info word, no descriptor update and no interrupt. The new message is then handled normally. A command that arrives during reception before the gap has elapsed is reported as a protocol error instead. A command that arrives while the terminal is idle simply starts a message.

The gap threshold is `GAP_CYC = ceil(CLK_MHZ * 3.5)` clock cycles. All outputs are registered and appear one cycle after the strobe that causes them.

Top module: `sup_det`

## Requirements
- R1: With `rx_busy` and `tx_busy` both low, a command strobe on bus b gives `start_o`=1 with `new_bus_o`=b one cycle later, and `abort_o`=0.
- R2: While `rx_busy`=1, a command on the active bus `cur_bus` that comes k cycles after the last word on that bus, with k >= GAP_CYC, gives `abort_o`, `start_o` and `quash_o` together one cycle later, with `new_bus_o` equal to the active bus.
- R3: Under the same conditions as R2, a command on the other bus supersedes in the same way, with `new_bus_o` equal to the other bus.
- R4: While `rx_busy`=1, a command that comes with k < GAP_CYC gives `proto_err_o`=1 one cycle later, with no abort and no start, and `new_bus_o` unchanged.
- R5: While `tx_busy`=1, a command on the bus other than `cur_bus` supersedes at once, whatever the gap: abort, start and quash are all high, and `new_bus_o` is the other bus.
- R6: While `tx_busy`=1, a command on `cur_bus` alone is ignored: no pulse on any output, and `new_bus_o` unchanged.
- R7: Any command or data strobe on `cur_bus` restarts the gap count. Strobes on the other bus do not restart it.
- R8: `abort_o`, `start_o`, `quash_o` and `proto_err_o` are one cycle wide. `new_bus_o` changes only in a cycle where `start_o` is high, and holds otherwise.
- R9: If commands arrive on both buses in the same cycle, bus 0 wins, except during transmit, where the bus other than `cur_bus` wins. The bus encoding is 0 and 1.
- R10: During and right after reset, all pulse outputs are 0 and `new_bus_o` is 0.
- R11: `quash_o` is high exactly in the cycles where `abort_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 2 | Valid command word strobe, one bit per bus |
| dat_vld | input | 2 | Valid data word strobe, one bit per bus |
| rx_busy | input | 1 | An incoming message is in progress and incomplete |
| tx_busy | input | 1 | The terminal is transmitting its response |
| cur_bus | input | 1 | Bus of the current message |
| abort_o | output | 1 | Drop the current message (pulse) |
| start_o | output | 1 | Start of a new message (pulse) |
| quash_o | output | 1 | Skip all bookkeeping for the dropped message (pulse) |
| proto_err_o | output | 1 | Command arrived before the idle gap elapsed (pulse) |
| new_bus_o | output | 1 | Bus of the most recently started message |

## Verification
The bench runs a small configuration in which GAP_CYC is 7. It sweeps the distance from the last word to the new command over 1 to 12 cycles, for every pairing of active bus and command bus, so an off-by-one in the gap counter shows up as a supersede or an error on the wrong side of 7. It checks that a word on the other bus does not restart the count while a word on the active bus does; a design that mixed up the two would either abort too early or report errors it should not. The transmit cases check that a cross-bus command aborts even one cycle after the last word, that a same-bus command leaves every output quiet, and how ties are broken when both buses strobe at once. A design with the wrong bus priority would latch the wrong bus number.

// File: rtl/sup_det.sv
module sup_det #(
  parameter int CLK_MHZ = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cmd_vld,
  input  logic [1:0] dat_vld,
  input  logic       rx_busy,
  input  logic       tx_busy,
  input  logic       cur_bus,
  output logic       abort_o,
  output logic       start_o,
  output logic       quash_o,
  output logic       proto_err_o,
  output logic       new_bus_o
);
  localparam int GAP_CYC = (CLK_MHZ * 7 + 1) / 2;
  localparam int GAP_LIM = (GAP_CYC > 0) ? GAP_CYC - 1 : 0;
  localparam int CW      = $clog2(GAP_CYC + 1) + 1;

  logic [CW-1:0] gap_cnt;
  logic          other, cur_word, gap_ok, any_cmd;
  logic          tx_sup, rx_sup, rx_err, idle_go, go, go_bus;

  assign other    = ~cur_bus;
  assign cur_word = cmd_vld[cur_bus] | dat_vld[cur_bus];
  assign gap_ok   = (gap_cnt == CW'(GAP_LIM));
  assign any_cmd  = |cmd_vld;

  assign tx_sup  = tx_busy & cmd_vld[other];
  assign rx_sup  = ~tx_busy & rx_busy & any_cmd & gap_ok;
  assign rx_err  = ~tx_busy & rx_busy & any_cmd & ~gap_ok;
  assign idle_go = ~tx_busy & ~rx_busy & any_cmd;
  assign go      = tx_sup | rx_sup | idle_go;
  assign go_bus  = tx_sup ? other : ~cmd_vld[0];

  always_ff @(posedge clk) begin
    if (!rst_n)            gap_cnt <= '0;
    else if (cur_word)     gap_cnt <= '0;
    else if (!gap_ok)      gap_cnt <= gap_cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abort_o     <= 1'b0;
      start_o     <= 1'b0;
      quash_o     <= 1'b0;
      proto_err_o <= 1'b0;
      new_bus_o   <= 1'b0;
    end else begin
      abort_o     <= tx_sup | rx_sup;
      quash_o     <= tx_sup | rx_sup;
      start_o     <= go;
      proto_err_o <= rx_err;
      if (go) new_bus_o <= go_bus;
    end
  end
endmodule

module sup_det_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cmd_vld,
  input logic       rx_busy,
  input logic       tx_busy,
  input logic       cur_bus,
  input logic       abort_o,
  input logic       start_o,
  input logic       quash_o,
  input logic       proto_err_o,
  input logic       new_bus_o
);
  a_r2_abort_starts: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (start_o && quash_o));

  a_r11_quash_only_abort: assert property (@(posedge clk) disable iff (!rst_n)
    quash_o |-> abort_o);

  a_r4_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |-> (!start_o && !abort_o));

  a_r8_bus_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !start_o |-> $stable(new_bus_o));

  a_r5_tx_cross: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_busy && cmd_vld[!cur_bus]) |-> (abort_o && new_bus_o != $past(cur_bus)));

  a_r6_tx_same_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_busy && !cmd_vld[!cur_bus]) |-> (!start_o && !proto_err_o));

  a_r1_idle_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!tx_busy && !rx_busy) |-> !abort_o);
endmodule

bind sup_det sup_det_chk u_chk (.*);

// File: tb/tb_sup_det.sv
`timescale 1ns/1ps
module tb_sup_det;
  localparam int MHZ = 2;
  localparam int GAP = (MHZ * 7 + 1) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cmd_vld = '0, dat_vld = '0;
  logic rx_busy = 1'b0, tx_busy = 1'b0, cur_bus = 1'b0;
  logic abort_o, start_o, quash_o, proto_err_o, new_bus_o;

  int checks = 0, errors = 0;
  logic exp_bus = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sup_det #(.CLK_MHZ(MHZ)) dut (.*);

  function automatic logic [4:0] ex(logic a, logic s, logic q, logic e, logic b);
    return {a, s, q, e, b};
  endfunction

  task automatic chk(input string tag, input logic [4:0] exp);
    logic [4:0] got;
    got = {abort_o, start_o, quash_o, proto_err_o, new_bus_o};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got abort/start/quash/err/bus=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic send(input logic [1:0] c, input logic [1:0] d);
    cmd_vld = c; dat_vld = d;
    @(negedge clk);
    cmd_vld = '0; dat_vld = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R10 reset", ex(0, 0, 0, 0, 0));
    rst_n = 1'b1;
    idle(1);
    chk("R10 after reset", ex(0, 0, 0, 0, 0));

    for (int b = 0; b < 2; b++) begin
      send(2'b01 << b, 2'b00);
      exp_bus = b[0];
      chk("R1 idle start", ex(0, 1, 0, 0, exp_bus));
      idle(1);
      chk("R8 pulse ends, bus held", ex(0, 0, 0, 0, exp_bus));
    end
    send(2'b11, 2'b00);
    exp_bus = 1'b0;
    chk("R9 idle tie bus0", ex(0, 1, 0, 0, 0));
    idle(1);

    for (int ab = 0; ab < 2; ab++)
      for (int nb = 0; nb < 2; nb++)
        for (int k = 1; k <= 12; k++) begin
          rx_busy = 1'b1; cur_bus = ab[0];
          send(2'b00, 2'b01 << ab);
          idle(k - 1);
          send(2'b01 << nb, 2'b00);
          if (k >= GAP) begin
            exp_bus = nb[0];
            chk(ab == nb ? "R2 same-bus supersede" : "R3 other-bus supersede",
                ex(1, 1, 1, 0, exp_bus));
          end else
            chk("R4 early command", ex(0, 0, 0, 1, exp_bus));
          rx_busy = 1'b0;
          idle(1);
          chk("R8 R11 quiet after", ex(0, 0, 0, 0, exp_bus));
        end

    rx_busy = 1'b1; cur_bus = 1'b0;
    send(2'b00, 2'b01);
    idle(3);
    send(2'b00, 2'b10);
    idle(2);
    send(2'b10, 2'b00);
    exp_bus = 1'b1;
    chk("R7 other-bus word no restart", ex(1, 1, 1, 0, 1));
    send(2'b00, 2'b01);
    idle(3);
    send(2'b00, 2'b01);
    idle(3);
    send(2'b01, 2'b00);
    chk("R7 active-bus word restarts", ex(0, 0, 0, 1, exp_bus));
    rx_busy = 1'b0;
    idle(1);

    for (int ab = 0; ab < 2; ab++) begin
      tx_busy = 1'b1; cur_bus = ab[0];
      send(2'b00, 2'b01 << ab);
      send(2'b01 << (1 - ab), 2'b00);
      exp_bus = ~ab[0];
      chk("R5 transmit cross-bus", ex(1, 1, 1, 0, exp_bus));
      send(2'b01 << ab, 2'b00);
      chk("R6 transmit same-bus ignored", ex(0, 0, 0, 0, exp_bus));
      cur_bus = ~ab[0];
      send(2'b11, 2'b00);
      exp_bus = ab[0];
      chk("R9 transmit tie other bus", ex(1, 1, 1, 0, exp_bus));
      tx_busy = 1'b0;
      idle(1);
      chk("R8 R11 quiet after", ex(0, 0, 0, 0, exp_bus));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule